// File: doc/BRIEF.md
# Circular DMA Buffer Address Generator

This block produces the memory byte address for a stream of serial samples moving into or out of a buffer in memory. Software supplies a base address, a buffer size and a mode, then raises the channel enable. Each accepted transfer request moves the address forward by one byte. In ring mode the address returns to the base after the last byte and keeps going. In one-pass mode it stops after a single pass and reports completion.

The block raises two sticky interrupt flags. One marks the transfer that completes the lower half of the buffer. The other marks the transfer that completes the whole buffer. Software can therefore refill or drain one half while the other half is in use. A chip uses two instances, one for receive and one for transmit. They can point at separate buffers or at the same buffer for loopback. A bypass input freezes the counter while software moves samples itself.

Top module: `dmag_top`

## Requirements
- R1: After reset, addr_o is 0 and irq_half_o, irq_end_o and done_o are 0.
- R2: A rising edge of en_i is seen at the next clock. On that clock the block captures base_i, the legalised size and the mode, sets addr_o to base_i and clears done_o.
- R3: When en_i has been high for more than one cycle, bypass_i is low, done_o is low and req_i is high, addr_o rises by one on that clock.
- R4: The size used is the largest power of two that does not exceed size_i. It is limited to the range 16 to 16384, and any value below 16 gives 16.
- R5: With one_shot_i low at enable, a transfer at offset size-1 returns addr_o to the base, and later requests keep advancing it.
- R6: With one_shot_i high at enable, a transfer at offset size-1 returns addr_o to the base and sets done_o. While done_o is set, requests leave addr_o unchanged. The next enable rising edge clears done_o.
- R7: irq_half_o is set by the transfer at offset size/2-1.
- R8: irq_end_o is set by the transfer at offset size-1.
- R9: Both flags stay set until cleared through irq_clr_i, where bit 0 clears irq_half_o and bit 1 clears irq_end_o. If a flag is set and cleared on the same clock, it ends up set.
- R10: While bypass_i is high, requests leave addr_o unchanged.
- R11: While en_i is low, requests leave addr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; a rising edge reloads the address |
| one_shot_i | input | 1 | 1 = stop after one pass, 0 = ring mode |
| bypass_i | input | 1 | Direct software mode; the counter is frozen |
| base_i | input | 32 | Buffer base byte address |
| size_i | input | 15 | Requested buffer size in bytes |
| req_i | input | 1 | Transfer request strobe, one byte per cycle high |
| irq_clr_i | input | 2 | Write-one-to-clear: bit 0 half flag, bit 1 end flag |
| addr_o | output | 32 | Current byte address |
| irq_half_o | output | 1 | Sticky half-buffer flag |
| irq_end_o | output | 1 | Sticky end-of-buffer flag |
| done_o | output | 1 | One-pass transfer complete |

## Verification
The assertions assume three things about the inputs. The captured size is always a legal power of two. base_i, size_i and one_shot_i matter only on the enable clock. Bypass and requests have effect only after the enable clock. The stimulus changes configuration only while en_i is low and then drives a separate rising edge of en_i. Requests are driven only in cycles after the reload clock. Bypass, enable-low and done windows are each checked on their own, so the hold checks see one cause at a time.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int IRQ_HALF = 0;
  localparam int IRQ_END  = 1;
  localparam int N_IRQ    = 2;

  typedef enum logic {
    MODE_RING = 1'b0,
    MODE_ONCE = 1'b1
  } dmag_mode_e;
endpackage

// File: rtl/dmag_size_legal.sv
module dmag_size_legal #(
  parameter int MIN_LOG = 4,
  parameter int MAX_LOG = 14,
  localparam int SZ_W = MAX_LOG + 1
) (
  input  logic [SZ_W-1:0] size_i,
  output logic [SZ_W-1:0] size_o
);
  // floor to power of two, clamped
  always_comb begin
    size_o = SZ_W'(1) << MIN_LOG;
    for (int i = MIN_LOG; i <= MAX_LOG; i++) begin
      if (size_i[i]) size_o = SZ_W'(1) << i;
    end
  end
endmodule

// File: rtl/dmag_offset_ctr.sv
module dmag_offset_ctr #(
  parameter int MIN_LOG = 4,
  parameter int MAX_LOG = 14,
  localparam int SZ_W  = MAX_LOG + 1,
  localparam int OFF_W = MAX_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [SZ_W-1:0]  size_i,
  input  dmag_pkg::dmag_mode_e mode_i,
  output logic [OFF_W-1:0] off_o,
  output logic             at_half_o,
  output logic             at_end_o,
  output logic             done_o
);
  import dmag_pkg::*;

  logic [OFF_W-1:0]  off_q;
  logic [SZ_W-1:0]   size_q;
  dmag_mode_e        mode_q;
  logic              done_q;

  assign at_end_o  = ({1'b0, off_q} == size_q - SZ_W'(1));
  assign at_half_o = ({1'b0, off_q} == (size_q >> 1) - SZ_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      size_q <= SZ_W'(1) << MIN_LOG;
      mode_q <= MODE_RING;
      done_q <= 1'b0;
    end else if (load_i) begin
      off_q  <= '0;
      size_q <= size_i;
      mode_q <= mode_i;
      done_q <= 1'b0;
    end else if (step_i) begin
      if (at_end_o) begin
        off_q <= '0;
        if (mode_q == MODE_ONCE) done_q <= 1'b1;
      end else begin
        off_q <= off_q + OFF_W'(1);
      end
    end
  end

  assign off_o  = off_q;
  assign done_o = done_q;

  p_off_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, off_q} < size_q);
  p_step_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && !at_end_o |=> off_q == $past(off_q) + OFF_W'(1));
  p_wrap_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && at_end_o |=> off_q == '0);
  p_done_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !load_i |=> $stable(off_q));
endmodule

// File: rtl/dmag_irq_flags.sv
module dmag_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i[g] |=> flag_q);
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q);
  end
endmodule

// File: rtl/dmag_top.sv
module dmag_top #(
  parameter int AW      = 32,
  parameter int MIN_LOG = 4,
  parameter int MAX_LOG = 14,
  localparam int SZ_W  = MAX_LOG + 1,
  localparam int OFF_W = MAX_LOG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            one_shot_i,
  input  logic            bypass_i,
  input  logic [AW-1:0]   base_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic            req_i,
  input  logic [1:0]      irq_clr_i,
  output logic [AW-1:0]   addr_o,
  output logic            irq_half_o,
  output logic            irq_end_o,
  output logic            done_o
);
  import dmag_pkg::*;

  logic             en_q;
  logic [AW-1:0]    base_q;
  logic [SZ_W-1:0]  size_legal;
  logic [OFF_W-1:0] off;
  logic             load, step, at_half, at_end, done;
  logic [N_IRQ-1:0] irq_set, irq_flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else begin
      en_q <= en_i;
      if (load) base_q <= base_i;
    end
  end

  assign load = en_i && !en_q;
  assign step = en_i && en_q && !bypass_i && !done && req_i;

  dmag_size_legal #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_size (
    .size_i (size_i),
    .size_o (size_legal)
  );

  dmag_offset_ctr #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (step),
    .size_i    (size_legal),
    .mode_i    (one_shot_i ? MODE_ONCE : MODE_RING),
    .off_o     (off),
    .at_half_o (at_half),
    .at_end_o  (at_end),
    .done_o    (done)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_HALF] = step && at_half;
    irq_set[IRQ_END]  = step && at_end;
  end

  dmag_irq_flags #(.N(N_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr_i),
    .flag_o (irq_flag)
  );

  assign addr_o     = base_q + AW'(off);
  assign irq_half_o = irq_flag[IRQ_HALF];
  assign irq_end_o  = irq_flag[IRQ_END];
  assign done_o     = done;

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      p_size_pow2_r4: assert ($onehot(size_legal) &&
                              size_legal >= (SZ_W'(1) << MIN_LOG));
    end
  end

  p_bypass_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && en_i && bypass_i |=> $stable(addr_o));
  p_disabled_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(addr_o));
  p_reload_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !en_q |=> addr_o == $past(base_i) && !done_o);
endmodule

// File: tb/dmag_top_test.sv
module dmag_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0, one_shot = 0, bypass = 0, req = 0;
  logic [31:0] base = '0;
  logic [14:0] size = 15'd16;
  logic [1:0]  clr = '0;
  logic [31:0] addr;
  logic        irq_half, irq_end, done;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  dmag_top uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .one_shot_i(one_shot),
    .bypass_i(bypass), .base_i(base), .size_i(size), .req_i(req),
    .irq_clr_i(clr), .addr_o(addr), .irq_half_o(irq_half),
    .irq_end_o(irq_end), .done_o(done)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reqs(int n);
    for (int i = 0; i < n; i++) begin
      req = 1'b1;
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  task automatic start(logic [31:0] b, logic [14:0] s, logic os);
    en = 1'b0;
    @(negedge clk);
    base = b; size = s; one_shot = os;
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear(logic [1:0] m);
    clr = m;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic t_reset;
    check("R1 addr", addr, 32'h0);
    check("R1 flags", {29'd0, irq_half, irq_end, done}, 32'h0);
  endtask

  task automatic t_enable;
    start(32'h1000, 15'd16, 1'b0);
    check("R2 reload", addr, 32'h1000);
    reqs(5);
    check("R3 step", addr, 32'h1005);
    en = 1'b0;
    @(negedge clk);
    reqs(3);
    check("R11 disabled hold", addr, 32'h1005);
    en = 1'b1;
    @(negedge clk);
    check("R2 re-enable reload", addr, 32'h1000);
  endtask

  task automatic t_ring;
    clear(2'b11);
    start(32'h2000, 15'd16, 1'b0);
    reqs(7);
    check("R7 half not yet", {31'd0, irq_half}, 32'd0);
    reqs(1);
    check("R7 half set", {31'd0, irq_half}, 32'd1);
    check("R8 end not yet", {31'd0, irq_end}, 32'd0);
    clear(2'b01);
    check("R9 w1c half", {31'd0, irq_half}, 32'd0);
    reqs(7);
    check("R5 last addr", addr, 32'h200F);
    reqs(1);
    check("R5 wrap", addr, 32'h2000);
    check("R8 end set", {31'd0, irq_end}, 32'd1);
    check("R5 no done", {31'd0, done}, 32'd0);
    reqs(3);
    check("R5 keeps running", addr, 32'h2003);
    check("R9 end sticky", {31'd0, irq_end}, 32'd1);
    clear(2'b10);
    check("R9 w1c end", {31'd0, irq_end}, 32'd0);
  endtask

  task automatic t_set_wins;
    clear(2'b11);
    start(32'h3000, 15'd16, 1'b0);
    reqs(7);
    clr = 2'b01;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0; clr = 2'b00;
    check("R9 set wins", {31'd0, irq_half}, 32'd1);
  endtask

  task automatic t_once;
    clear(2'b11);
    start(32'h4000, 15'd32, 1'b1);
    reqs(31);
    check("R6 not done", {31'd0, done}, 32'd0);
    reqs(1);
    check("R6 done", {31'd0, done}, 32'd1);
    check("R6 addr base", addr, 32'h4000);
    check("R8 end once", {31'd0, irq_end}, 32'd1);
    reqs(4);
    check("R6 ignored", addr, 32'h4000);
    start(32'h4000, 15'd32, 1'b1);
    check("R6 done cleared", {31'd0, done}, 32'd0);
    reqs(2);
    check("R6 runs again", addr, 32'h4002);
  endtask

  task automatic t_bypass;
    start(32'h5000, 15'd16, 1'b0);
    reqs(2);
    bypass = 1'b1;
    @(negedge clk);
    reqs(4);
    check("R10 bypass hold", addr, 32'h5002);
    bypass = 1'b0;
    reqs(1);
    check("R10 resume", addr, 32'h5003);
  endtask

  task automatic t_size;
    clear(2'b11);
    start(32'h6000, 15'd100, 1'b0);
    reqs(63);
    check("R4 size 100 addr", addr, 32'h603F);
    reqs(1);
    check("R4 size 100 -> 64", addr, 32'h6000);
    check("R4 end at 64", {31'd0, irq_end}, 32'd1);
    clear(2'b11);
    start(32'h7000, 15'd3, 1'b0);
    reqs(16);
    check("R4 size 3 -> 16", addr, 32'h7000);
    clear(2'b11);
    start(32'h10000, 15'd20000, 1'b0);
    reqs(8191);
    check("R7 half 16384 not yet", {31'd0, irq_half}, 32'd0);
    reqs(1);
    check("R7 half 16384", {31'd0, irq_half}, 32'd1);
    reqs(8191);
    check("R4 size 20000 last", addr, 32'h13FFF);
    reqs(1);
    check("R4 size 20000 -> 16384", addr, 32'h10000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_enable;
        t_ring;
        t_set_wins;
        t_once;
        t_bypass;
        t_size;
      end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule